// File: doc/BRIEF.md
# Programmable Pixel Clock Shaper

The block turns a fast reference tick into a display pixel clock whose period and whose high phase are both programmable with sub-tick resolution. Software-side logic presents a single configuration beat with three values:
- a period divider in reference ticks, carrying four fractional bits;
- a start position for the high phase, in sixteenths of the period;
- a width for the high phase, also in sixteenths of the period.

The block clamps the divider to its legal range. It replaces an unusable start/width pair with a fixed fallback shape. It then converts the pair into rising and falling edge positions with two fractional bits and holds the result as one packed timing word.

A fractional period is produced by carrying the sub-tick remainder from one period to the next. Each period boundary therefore lands on the first whole tick at or after its ideal position, and the long-run average period equals the programmed value. Inside each period the clock is high from the integer part of the rising-edge value up to, but not including, the integer part of the falling-edge value. A one-tick strobe marks the first tick of every period. A new shape takes effect only at a period boundary.

Top module: `pixclk_shaper`

## Requirements
- R1: One cycle after a cycle with `cfg_valid` high, `timing_word` holds the converted configuration: the clamped divider in bits 11:0 (4 fractional bits), the rising edge in bits 21:12 and the falling edge in bits 31:22 (both with 2 fractional bits).
- R2: A divider below 0x40 (4.0 ticks) is raised to 0x40.
- R3: A divider above 0xFFF is clamped to 0xFFF.
- R4: With clamped divider D and sixteenths S (start) and W (width), rising = floor(floor(D*S/16)/4) and falling = floor(floor(D*(S+W)/16)/4).
- R5: If S and W are both zero, or S+W exceeds 16, the block uses S=0 and W=7 instead.
- R6: Every period lasts floor(D/16) or ceil(D/16) ticks, and any 16 consecutive periods together last exactly D ticks.
- R7: Within a period, with tick index i counted from 0 at the boundary, `pix_clk` is high exactly when rising/4 <= i < falling/4, using integer parts. For example, a divider of 94.0 ticks with the fallback shape gives 41 high ticks.
- R8: `pix_strobe` is high for exactly the first tick of each period and for no other tick.
- R9: A configuration accepted in the middle of a period leaves the shape and length of that period unchanged. It takes effect from the next boundary.
- R10: While `rst` is high, `pix_clk` and `pix_strobe` are low and `timing_word` holds the fallback shape for the reset divider 0x40, which is 0x01C00040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Accept the configuration on this cycle |
| cfg_div | input | 16 | Period divider, 4 fractional bits |
| cfg_start | input | 5 | High-phase start, sixteenths of a period |
| cfg_width | input | 5 | High-phase width, sixteenths of a period |
| pix_clk | output | 1 | Shaped pixel clock |
| pix_strobe | output | 1 | High on the first tick of each period |
| timing_word | output | 32 | Packed pending timing word |

## Verification
The properties assume that reset is asserted before the first useful cycle and that `cfg_valid` may arrive in any tick, including a boundary tick. They place no limit on the divider, start or width values, because the converter must absorb any input. The stimulus follows these assumptions: it sweeps every 5-bit start and width against dividers below, inside and above the legal range. It issues one configuration at a known tick inside a running period, so that the boundary-only takeover is exercised. Waveform checks begin only after two boundaries have passed since the last configuration, so every measured period belongs to a single shape.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
   localparam int SIXTEENTHS = 16;

   // edge position = floor(floor(div * n / 16) >> drop), truncating twice
   function automatic logic [31:0] frac_edge(input logic [31:0] div_q,
                                             input logic [31:0] n16,
                                             input int          drop);
      logic [31:0] prod;
      prod = div_q * n16;
      return (prod / SIXTEENTHS) >> drop;
   endfunction
endpackage

// File: rtl/pxs_shape_conv.sv
module pxs_shape_conv #(
   parameter int IN_DIV_W  = 16,
   parameter int DIV_W     = 12,
   parameter int FRAC_P    = 4,
   parameter int EDGE_W    = 10,
   parameter int FRAC_E    = 2,
   parameter int SIX_W     = 5,
   parameter int DEF_START = 0,
   parameter int DEF_WIDTH = 7,
   localparam int WORD_W   = DIV_W + 2 * EDGE_W
) (
   input  logic [IN_DIV_W-1:0] div_in,
   input  logic [SIX_W-1:0]    start_in,
   input  logic [SIX_W-1:0]    width_in,
   output logic [WORD_W-1:0]   word
);
   import pxs_pkg::*;

   localparam int DIV_MIN = 4 << FRAC_P;
   localparam int DIV_MAX = (1 << DIV_W) - 1;

   logic [DIV_W-1:0] div_hi;   // after upper clamp
   logic [DIV_W-1:0] div_c;    // after both clamps
   logic [SIX_W:0]   sum16;
   logic             shape_ok;
   logic [SIX_W-1:0] s_eff, w_eff;
   logic [EDGE_W-1:0] rise_v, fall_v;

   generate
      if (IN_DIV_W > DIV_W) begin : g_clamp_top
         always_comb
            div_hi = (32'(div_in) > DIV_MAX) ? DIV_W'(DIV_MAX) : DIV_W'(div_in);
      end else begin : g_no_clamp_top
         always_comb div_hi = DIV_W'(div_in);
      end
   endgenerate

   always_comb begin
      div_c    = (32'(div_hi) < DIV_MIN) ? DIV_W'(DIV_MIN) : div_hi;
      sum16    = (SIX_W+1)'(start_in) + (SIX_W+1)'(width_in);
      shape_ok = (sum16 != '0) && (32'(sum16) <= SIXTEENTHS);
      s_eff    = shape_ok ? start_in : SIX_W'(DEF_START);
      w_eff    = shape_ok ? width_in : SIX_W'(DEF_WIDTH);
      rise_v   = EDGE_W'(frac_edge(32'(div_c), 32'(s_eff), FRAC_P - FRAC_E));
      fall_v   = EDGE_W'(frac_edge(32'(div_c), 32'(s_eff) + 32'(w_eff), FRAC_P - FRAC_E));
      word     = {fall_v, rise_v, div_c};
   end
endmodule

// File: rtl/pxs_period.sv
module pxs_period #(
   parameter int DIV_W  = 12,
   parameter int FRAC_P = 4,
   parameter int TICK_W = DIV_W - FRAC_P + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DIV_W-1:0]  div_pend,
   output logic              bnd,
   output logic [TICK_W-1:0] cnt_nxt,
   output logic [TICK_W-1:0] cnt_q,
   output logic [TICK_W-1:0] len_q
);
   logic [FRAC_P-1:0] res_q, res_n;   // actual start minus ideal start, in 1/16 tick
   logic [DIV_W-1:0]  rem;
   logic [DIV_W:0]    rem_up;
   logic [TICK_W-1:0] len_n;

   always_comb begin
      bnd     = (cnt_q == TICK_W'(len_q - 1'b1));
      cnt_nxt = bnd ? '0 : TICK_W'(cnt_q + 1'b1);
      rem     = div_pend - DIV_W'(res_q);
      rem_up  = (DIV_W+1)'(rem) + (DIV_W+1)'((1 << FRAC_P) - 1);
      len_n   = TICK_W'(rem_up >> FRAC_P);
      res_n   = FRAC_P'(0) - rem[FRAC_P-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         len_q <= TICK_W'(1);
         res_q <= '0;
      end else begin
         cnt_q <= cnt_nxt;
         if (bnd) begin
            len_q <= len_n;
            res_q <= res_n;
         end
      end
   end
endmodule

// File: rtl/pxs_wave.sv
module pxs_wave #(
   parameter int EINT_W = 8,
   parameter int TICK_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bnd,
   input  logic [TICK_W-1:0] cnt_nxt,
   input  logic [EINT_W-1:0] pend_rise,
   input  logic [EINT_W-1:0] pend_fall,
   input  logic [EINT_W-1:0] rst_rise,
   input  logic [EINT_W-1:0] rst_fall,
   output logic [EINT_W-1:0] act_rise,
   output logic [EINT_W-1:0] act_fall,
   output logic              pix,
   output logic              stb
);
   logic [EINT_W-1:0] rise_n, fall_n;

   always_comb begin
      rise_n = bnd ? pend_rise : act_rise;
      fall_n = bnd ? pend_fall : act_fall;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         act_rise <= rst_rise;
         act_fall <= rst_fall;
         pix      <= 1'b0;
         stb      <= 1'b0;
      end else begin
         act_rise <= rise_n;
         act_fall <= fall_n;
         pix      <= (cnt_nxt >= TICK_W'(rise_n)) && (cnt_nxt < TICK_W'(fall_n));
         stb      <= bnd;
      end
   end
endmodule

// File: rtl/pixclk_shaper.sv
module pixclk_shaper #(
   parameter int IN_DIV_W  = 16,
   parameter int DIV_W     = 12,
   parameter int FRAC_P    = 4,
   parameter int EDGE_W    = 10,
   parameter int FRAC_E    = 2,
   parameter int SIX_W     = 5,
   parameter int DEF_START = 0,
   parameter int DEF_WIDTH = 7,
   parameter int RST_DIV   = 64,
   localparam int WORD_W   = DIV_W + 2 * EDGE_W,
   localparam int TICK_W   = DIV_W - FRAC_P + 1,
   localparam int EINT_W   = EDGE_W - FRAC_E
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cfg_valid,
   input  logic [IN_DIV_W-1:0] cfg_div,
   input  logic [SIX_W-1:0]    cfg_start,
   input  logic [SIX_W-1:0]    cfg_width,
   output logic                pix_clk,
   output logic                pix_strobe,
   output logic [WORD_W-1:0]   timing_word
);
   initial begin : elab_checks
      assert (FRAC_P >= FRAC_E) else $error("period needs at least as many fraction bits as edges");
      assert (EDGE_W >= DIV_W - (FRAC_P - FRAC_E)) else $error("edge field too narrow for the period");
      assert (DEF_START + DEF_WIDTH <= 16 && DEF_START + DEF_WIDTH > 0) else $error("fallback shape illegal");
      assert ((1 << SIX_W) > 16) else $error("start/width field cannot express 16");
   end

   logic [WORD_W-1:0] conv_word, rst_word, pend_q;
   logic              bnd_w;
   logic [TICK_W-1:0] cnt_nxt_w, cnt_w, len_w;
   logic [EINT_W-1:0] act_rise_w, act_fall_w;

   pxs_shape_conv #(.IN_DIV_W(IN_DIV_W), .DIV_W(DIV_W), .FRAC_P(FRAC_P), .EDGE_W(EDGE_W),
                    .FRAC_E(FRAC_E), .SIX_W(SIX_W), .DEF_START(DEF_START), .DEF_WIDTH(DEF_WIDTH))
   u_conv (.div_in(cfg_div), .start_in(cfg_start), .width_in(cfg_width), .word(conv_word));

   // constant inputs: reset word is the fallback shape on the reset divider
   pxs_shape_conv #(.IN_DIV_W(IN_DIV_W), .DIV_W(DIV_W), .FRAC_P(FRAC_P), .EDGE_W(EDGE_W),
                    .FRAC_E(FRAC_E), .SIX_W(SIX_W), .DEF_START(DEF_START), .DEF_WIDTH(DEF_WIDTH))
   u_rst_conv (.div_in(IN_DIV_W'(RST_DIV)), .start_in('0), .width_in('0), .word(rst_word));

   always_ff @(posedge clk) begin
      if (rst)            pend_q <= rst_word;
      else if (cfg_valid) pend_q <= conv_word;
   end

   pxs_period #(.DIV_W(DIV_W), .FRAC_P(FRAC_P), .TICK_W(TICK_W))
   u_period (.clk(clk), .rst(rst), .div_pend(pend_q[DIV_W-1:0]), .bnd(bnd_w),
             .cnt_nxt(cnt_nxt_w), .cnt_q(cnt_w), .len_q(len_w));

   pxs_wave #(.EINT_W(EINT_W), .TICK_W(TICK_W))
   u_wave (.clk(clk), .rst(rst), .bnd(bnd_w), .cnt_nxt(cnt_nxt_w),
           .pend_rise(pend_q[DIV_W+FRAC_E +: EINT_W]),
           .pend_fall(pend_q[DIV_W+EDGE_W+FRAC_E +: EINT_W]),
           .rst_rise(rst_word[DIV_W+FRAC_E +: EINT_W]),
           .rst_fall(rst_word[DIV_W+EDGE_W+FRAC_E +: EINT_W]),
           .act_rise(act_rise_w), .act_fall(act_fall_w),
           .pix(pix_clk), .stb(pix_strobe));

   assign timing_word = pend_q;
endmodule

// File: rtl/pxs_shape_chk.sv
module pxs_shape_chk #(
   parameter int DIV_W  = 12,
   parameter int FRAC_P = 4,
   parameter int EDGE_W = 10,
   parameter int FRAC_E = 2,
   parameter int TICK_W = 9,
   parameter int EINT_W = 8
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        pix_clk,
   input logic                        pix_strobe,
   input logic [DIV_W+2*EDGE_W-1:0]   timing_word,
   input logic                        bnd,
   input logic [TICK_W-1:0]           cnt,
   input logic [TICK_W-1:0]           len,
   input logic [EINT_W-1:0]           act_rise,
   input logic [EINT_W-1:0]           act_fall
);
   localparam int DIV_MIN = 4 << FRAC_P;

   logic [DIV_W-1:0]  f_div;
   logic [EDGE_W-1:0] f_rise, f_fall;
   assign f_div  = timing_word[DIV_W-1:0];
   assign f_rise = timing_word[DIV_W +: EDGE_W];
   assign f_fall = timing_word[DIV_W+EDGE_W +: EDGE_W];

   assert_div_floor_R2: assert property (@(posedge clk) disable iff (rst)
      32'(f_div) >= DIV_MIN);

   assert_edges_in_period_R4: assert property (@(posedge clk) disable iff (rst)
      (f_rise <= f_fall) && (32'(f_fall) <= (32'(f_div) >> (FRAC_P - FRAC_E))));

   assert_count_in_len_R6: assert property (@(posedge clk) disable iff (rst)
      cnt < len);

   assert_high_window_R7: assert property (@(posedge clk) disable iff (rst)
      pix_clk |-> (cnt >= TICK_W'(act_rise)) && (cnt < TICK_W'(act_fall)));

   assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
      pix_strobe |=> !pix_strobe);

   assert_shape_held_R9: assert property (@(posedge clk) disable iff (rst)
      !bnd |=> $stable(act_rise) && $stable(act_fall));
endmodule

bind pixclk_shaper pxs_shape_chk #(.DIV_W(DIV_W), .FRAC_P(FRAC_P), .EDGE_W(EDGE_W),
                                   .FRAC_E(FRAC_E), .TICK_W(TICK_W), .EINT_W(EINT_W))
   u_shape_chk (.clk(clk), .rst(rst), .pix_clk(pix_clk), .pix_strobe(pix_strobe),
                .timing_word(timing_word), .bnd(bnd_w), .cnt(cnt_w), .len(len_w),
                .act_rise(act_rise_w), .act_fall(act_fall_w));

// File: tb/tb_pixclk_shaper.sv
`timescale 1ns/1ps
module tb_pixclk_shaper;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_valid = 1'b0;
   logic [15:0] cfg_div = '0;
   logic [4:0]  cfg_start = '0;
   logic [4:0]  cfg_width = '0;
   logic        pix_clk, pix_strobe;
   logic [31:0] timing_word;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pixclk_shaper dut (.clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_div(cfg_div),
                      .cfg_start(cfg_start), .cfg_width(cfg_width),
                      .pix_clk(pix_clk), .pix_strobe(pix_strobe), .timing_word(timing_word));

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
      end
   endtask

   function automatic int clamp_div(input int d);
      return (d < 64) ? 64 : ((d > 4095) ? 4095 : d);
   endfunction

   function automatic logic [31:0] exp_word(input int d, input int s, input int w);
      int dc, ss, ww, r, f;
      dc = clamp_div(d);
      if ((s == 0 && w == 0) || (s + w > 16)) begin ss = 0; ww = 7; end
      else begin ss = s; ww = w; end
      r = ((dc * ss) / 16) / 4;
      f = ((dc * (ss + ww)) / 16) / 4;
      return 32'((f << 22) | (r << 12) | dc);
   endfunction

   task automatic apply_cfg(input int d, input int s, input int w);
      @(negedge clk);
      cfg_div = 16'(d); cfg_start = 5'(s); cfg_width = 5'(w); cfg_valid = 1'b1;
      @(negedge clk);
      cfg_valid = 1'b0;
   endtask

   task automatic wait_strobe();
      int guard = 0;
      do begin @(negedge clk); guard++; end while (!pix_strobe && guard < 6000);
   endtask

   // Entered at a negedge whose cycle is tick 0 of a period; leaves at the next tick 0.
   task automatic one_period(input int apply_idx, input int d, input int s, input int w,
                             output int len, output int hi, output int first);
      len = 0; hi = 0; first = -1;
      do begin
         if (pix_clk) begin
            if (first < 0) first = len;
            hi++;
         end
         if (len == apply_idx) begin
            cfg_div = 16'(d); cfg_start = 5'(s); cfg_width = 5'(w); cfg_valid = 1'b1;
         end
         len++;
         @(negedge clk);
         cfg_valid = 1'b0;
      end while (!pix_strobe && len < 6000);
   endtask

   task automatic check_period(input int d, input int s, input int w,
                               input int len, input int hi, input int first, input string tag);
      logic [31:0] ew;
      int dc, ri, fi;
      ew = exp_word(d, s, w);
      dc = clamp_div(d);
      ri = int'(ew[21:12]) / 4;
      fi = int'(ew[31:22]) / 4;
      check(len == dc / 16 || len == (dc + 15) / 16, "R6", {tag, " period length"}, len, (dc + 15) / 16);
      check(hi == fi - ri, "R7", {tag, " high ticks"}, hi, fi - ri);
      if (fi > ri)
         check(first == ri, "R8", {tag, " rising tick after strobe"}, first, ri);
   endtask

   task automatic run_shape(input int d, input int s, input int w, input string tag);
      int len, hi, first, total;
      apply_cfg(d, s, w);
      wait_strobe();
      wait_strobe();
      total = 0;
      for (int k = 0; k < 16; k++) begin
         one_period(-1, 0, 0, 0, len, hi, first);
         check_period(d, s, w, len, hi, first, tag);
         total += len;
      end
      check(total == clamp_div(d), "R6", {tag, " 16-period sum"}, total, clamp_div(d));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      int len, hi, first;
      int divs [8] = '{16, 64, 69, 424, 1504, 4095, 8192, 65535};
      repeat (3) @(negedge clk);
      // R10: reset state
      check(pix_clk == 1'b0, "R10", "pix_clk in reset", pix_clk, 0);
      check(pix_strobe == 1'b0, "R10", "pix_strobe in reset", pix_strobe, 0);
      check(timing_word == 32'h01C0_0040, "R10", "timing_word in reset", timing_word, 32'h01C0_0040);
      rst = 1'b0;

      // R1..R5: conversion sweep over all start/width codes
      foreach (divs[i]) begin
         for (int s = 0; s < 32; s++) begin
            for (int w = 0; w < 32; w++) begin
               logic [31:0] ew;
               string rq;
               ew = exp_word(divs[i], s, w);
               if (divs[i] < 64) rq = "R2";
               else if (divs[i] > 4095) rq = "R3";
               else if ((s == 0 && w == 0) || s + w > 16) rq = "R5";
               else rq = "R4";
               apply_cfg(divs[i], s, w);
               check(timing_word == ew, rq, "R1 packed timing word", timing_word, ew);
            end
         end
      end

      // R6/R7/R8: waveform under several shapes
      run_shape(1504, 0, 0, "fallback 94.0");
      check(int'(exp_word(1504, 0, 0) >> 22) / 4 == 41, "R7", "94-tick example high phase",
            int'(exp_word(1504, 0, 0) >> 22) / 4, 41);
      run_shape(64, 0, 16, "4.0 full high");
      run_shape(69, 4, 6, "4.3125");
      run_shape(424, 8, 8, "26.5 late half");
      run_shape(16, 3, 13, "clamped low");
      run_shape(8192, 4, 6, "clamped high");
      run_shape(1504, 9, 9, "94.0 bad sum");

      // R9: mid-period change keeps current period, applies at next boundary
      run_shape(1504, 0, 7, "before change");
      one_period(2, 424, 4, 6, len, hi, first);
      check(hi == 41, "R9", "period with mid-change keeps old high", hi, 41);
      check(len == 94, "R9", "period with mid-change keeps old length", len, 94);
      one_period(-1, 0, 0, 0, len, hi, first);
      check_period(424, 4, 6, len, hi, first, "R9 after change");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule